// File: doc/BRIEF.md
# Station Address ROM Loader

After reset, this block fetches an eight-byte station-address record from a byte-wide ROM. The record bytes are not packed together. Byte j of the record sits at ROM address j times sixteen. Every byte is also stored with its bit order mirrored. The loader mirrors each byte back. It keeps the first six corrected bytes as the 48-bit station (MAC) address.

The block also folds all eight corrected bytes together with XOR. It declares the record good only when that fold equals 0xFF. A system controller pulses `start` and waits for the single-cycle `done` pulse. It then reads `mac_addr` and `valid`. When `valid` is low, the network device is treated as absent.

The ROM port has a fixed read latency of one cycle. The loader issues one read, waits one cycle for the data, then moves to the next byte.

Top module: `macid_rom_loader`

## Requirements
- R1: While reset is asserted and after its release, `done`, `valid` and `rom_rd` are 0 and `mac_addr` is all zeros until a load completes.
- R2: A load issues exactly eight ROM reads, in ascending order, at addresses 0, 16, 32, …, 112 (address = byte index × 16). The `rom_rd` strobe is never high in two consecutive cycles.
- R3: Each ROM byte is bit-mirrored (bit 0 ↔ bit 7, bit 1 ↔ bit 6, and so on) before use. For example, ROM value 0x01 yields the octet 0x80.
- R4: Corrected bytes 0 to 5 form `mac_addr`, with byte 0 in bits [47:40] and byte 5 in bits [7:0]. Bytes 6 and 7 never affect `mac_addr`.
- R5: `valid` is 1 after a load exactly when the XOR of all eight corrected bytes equals 0xFF.
- R6: When the XOR differs from 0xFF, `valid` is 0 after the load. `mac_addr` still shows the six corrected bytes.
- R7: `done` is high for exactly one cycle per load. It rises 16 clock edges after the edge that samples `start`, which is two cycles after the eighth read strobe.
- R8: `mac_addr` and `valid` change only in the cycle in which `done` is high. At all other times they hold their values, even when the ROM contents change.
- R9: A `start` pulse that arrives while a load is in progress is ignored. The running load still makes eight reads and gives one `done` pulse.
- R10: No ROM read is issued while the loader is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released internally in step with `clk` |
| start | input | 1 | Begins a load when the loader is idle |
| rom_rd | output | 1 | ROM read strobe |
| rom_addr | output | ADDR_W | ROM read address |
| rom_data | input | 8 | ROM read data, valid one cycle after `rom_rd` |
| mac_addr | output | 48 | Station address, first octet in the top bits |
| valid | output | 1 | Record checksum good |
| done | output | 1 | One-cycle pulse when a load finishes |

## Verification
The assertions assume the ROM returns its data in the cycle right after the strobe and that `start` is only a short pulse. The bench ROM model is a registered array read on `rom_rd`, so this latency always holds.

The bench changes ROM contents only while the loader is idle, or on purpose after a load to show that the outputs hold (R8). It pulses `start` for a single cycle, apart from the one scenario that deliberately pulses it again during a load (R9).

// File: rtl/macid_pkg.sv
package macid_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_ISSUE = 2'd1,
    SQ_CAPT  = 2'd2
  } seq_state_t;

  localparam logic [7:0] RECORD_GOOD = 8'hFF;

  function automatic logic [7:0] mirror8(input logic [7:0] b);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = b[7-i];
    return r;
  endfunction
endpackage

// File: rtl/macid_seq.sv
module macid_seq
  import macid_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int STRIDE_LOG2 = 4,
  parameter int NUM_BYTES   = 8,
  localparam int IDX_W      = $clog2(NUM_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              rom_rd,
  output logic [ADDR_W-1:0] rom_addr,
  output logic              cap_en,
  output logic [IDX_W-1:0]  cap_idx,
  output logic              cap_last
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_BYTES - 1);

  seq_state_t state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic idx_en;

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    idx_en  = 1'b0;
    unique case (state_q)
      SQ_IDLE:  if (start) state_d = SQ_ISSUE;
      SQ_ISSUE: state_d = SQ_CAPT;
      SQ_CAPT: begin
        idx_en = 1'b1;
        if (idx_q == LAST_IDX) begin
          state_d = SQ_IDLE;
          idx_d   = '0;
        end else begin
          state_d = SQ_ISSUE;
          idx_d   = idx_q + 1'b1;
        end
      end
      default: state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SQ_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx_q <= '0;
    else if (idx_en) idx_q <= idx_d;
  end

  assign rom_rd   = (state_q == SQ_ISSUE);
  assign rom_addr = rom_rd ? (ADDR_W'(idx_q) << STRIDE_LOG2) : '0;
  assign cap_en   = (state_q == SQ_CAPT);
  assign cap_idx  = idx_q;
  assign cap_last = (idx_q == LAST_IDX);
endmodule

// File: rtl/macid_acc.sv
module macid_acc
  import macid_pkg::*;
#(
  parameter int NUM_BYTES  = 8,
  parameter int ADDR_BYTES = 6,
  localparam int IDX_W     = $clog2(NUM_BYTES),
  localparam int MAC_W     = 8 * ADDR_BYTES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_en,
  input  logic [IDX_W-1:0] cap_idx,
  input  logic             cap_last,
  input  logic [7:0]       rom_data,
  output logic [MAC_W-1:0] mac_addr,
  output logic             valid,
  output logic             done
);
  logic [7:0]       fixed_byte;
  logic [7:0]       fold_q, fold_d;
  logic [MAC_W-1:0] shadow_flat;
  logic             commit;
  logic             fold_good;

  assign fixed_byte = mirror8(rom_data);
  assign fold_d     = (cap_idx == '0) ? fixed_byte : (fold_q ^ fixed_byte);
  assign commit     = cap_en && cap_last;
  assign fold_good  = (fold_d == RECORD_GOOD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      fold_q <= '0;
    else if (cap_en) fold_q <= fold_d;
  end

  for (genvar k = 0; k < ADDR_BYTES; k++) begin : g_octet
    logic [7:0] oct_q;
    logic       oct_en;
    assign oct_en = cap_en && (cap_idx == IDX_W'(k));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      oct_q <= '0;
      else if (oct_en) oct_q <= fixed_byte;
    end
    assign shadow_flat[MAC_W-1-8*k -: 8] = oct_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mac_addr <= '0;
      valid    <= 1'b0;
    end else if (commit) begin
      mac_addr <= shadow_flat;
      valid    <= fold_good;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done <= 1'b0;
    else        done <= commit;
  end
endmodule

// File: rtl/macid_rom_loader.sv
module macid_rom_loader
  import macid_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int STRIDE_LOG2 = 4,
  parameter int NUM_BYTES   = 8,
  parameter int ADDR_BYTES  = 6,
  localparam int IDX_W      = $clog2(NUM_BYTES),
  localparam int MAC_W      = 8 * ADDR_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              rom_rd,
  output logic [ADDR_W-1:0] rom_addr,
  input  logic [7:0]        rom_data,
  output logic [MAC_W-1:0]  mac_addr,
  output logic              valid,
  output logic              done
);
  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic             cap_en;
  logic             cap_last;
  logic [IDX_W-1:0] cap_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  macid_seq #(
    .ADDR_W(ADDR_W), .STRIDE_LOG2(STRIDE_LOG2), .NUM_BYTES(NUM_BYTES)
  ) u_seq (
    .clk(clk), .rst_n(rst_int_n), .start(start),
    .rom_rd(rom_rd), .rom_addr(rom_addr),
    .cap_en(cap_en), .cap_idx(cap_idx), .cap_last(cap_last)
  );

  macid_acc #(
    .NUM_BYTES(NUM_BYTES), .ADDR_BYTES(ADDR_BYTES)
  ) u_acc (
    .clk(clk), .rst_n(rst_int_n),
    .cap_en(cap_en), .cap_idx(cap_idx), .cap_last(cap_last),
    .rom_data(rom_data), .mac_addr(mac_addr), .valid(valid), .done(done)
  );
endmodule

// File: rtl/macid_rom_loader_chk.sv
module macid_rom_loader_chk #(
  parameter int ADDR_W      = 8,
  parameter int STRIDE_LOG2 = 4,
  parameter int NUM_BYTES   = 8,
  parameter int MAC_W       = 48
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rom_rd,
  input logic [ADDR_W-1:0] rom_addr,
  input logic [MAC_W-1:0]  mac_addr,
  input logic              valid,
  input logic              done
);
  localparam int IDX_W = $clog2(NUM_BYTES);
  logic [IDX_W-1:0] rd_seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rd_seen_q <= '0;
    else if (rom_rd) rd_seen_q <= rd_seen_q + 1'b1;
  end

  // R2: reads follow the ascending stride order, counted independently
  p_addr_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rom_rd |-> (rom_addr == (ADDR_W'(rd_seen_q) << STRIDE_LOG2)));

  // R2: strobe never back to back
  p_no_rd_burst_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rom_rd |=> !rom_rd);

  // R7: done is a single-cycle pulse
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7: done trails a read strobe by two cycles
  p_done_after_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(rom_rd, 2));

  // R8: address and validity hold outside the done cycle
  p_mac_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(mac_addr));

  p_valid_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(valid));
endmodule

bind macid_rom_loader macid_rom_loader_chk #(
  .ADDR_W(ADDR_W), .STRIDE_LOG2(STRIDE_LOG2), .NUM_BYTES(NUM_BYTES), .MAC_W(MAC_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .rom_rd(rom_rd), .rom_addr(rom_addr),
  .mac_addr(mac_addr), .valid(valid), .done(done)
);

// File: tb/macid_rom_loader_bench.sv
`timescale 1ns/1ps
module macid_rom_loader_bench;
  logic        clk;
  logic        rst_n;
  logic        start;
  logic        rom_rd;
  logic [7:0]  rom_addr;
  logic [7:0]  rom_data;
  logic [47:0] mac_addr;
  logic        valid;
  logic        done;

  logic [7:0] rom_mem [256];
  int total = 0;
  int bad = 0;
  int rd_cnt = 0;
  int rd_log [16];
  bit finished = 0;

  macid_rom_loader u_macid_rom_loader (
    .clk(clk), .rst_n(rst_n), .start(start), .rom_rd(rom_rd),
    .rom_addr(rom_addr), .rom_data(rom_data), .mac_addr(mac_addr),
    .valid(valid), .done(done)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always_ff @(posedge clk) if (rom_rd) rom_data <= rom_mem[rom_addr];

  always @(negedge clk) begin
    if (rom_rd) begin
      if (rd_cnt < 16) rd_log[rd_cnt] = int'(rom_addr);
      rd_cnt++;
    end
  end

  function automatic logic [7:0] flip(input logic [7:0] b);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = b[7-i];
    return r;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // store octets m0..m5, b6 and a last byte making fold good (or broken)
  task automatic put_record(input logic [47:0] m, input logic [7:0] b6, input bit good);
    logic [7:0] x;
    logic [7:0] b7;
    x = b6;
    for (int k = 0; k < 6; k++) begin
      rom_mem[k*16] = flip(m[47-8*k -: 8]);
      x ^= m[47-8*k -: 8];
    end
    b7 = 8'hFF ^ x;
    if (!good) b7 = b7 ^ 8'h10;
    rom_mem[96]  = flip(b6);
    rom_mem[112] = flip(b7);
  endtask

  task automatic run_load(output int lat);
    int k;
    rd_cnt = 0;
    @(negedge clk);
    start = 1'b1;
    k = 0;
    lat = -1;
    while (k < 100) begin
      @(negedge clk);
      k++;
      if (k == 1) start = 1'b0;
      if (done) begin lat = k; break; end
    end
    if (lat < 0) check("R7 done timeout", 0, 1);
  endtask

  task automatic t_reset();
    check("R1 done", done, 0);
    check("R1 valid", valid, 0);
    check("R1 rom_rd", rom_rd, 0);
    check("R1 mac", mac_addr, 0);
  endtask

  task automatic t_idle_quiet();
    rd_cnt = 0;
    repeat (10) @(negedge clk);
    check("R10 idle reads", rd_cnt, 0);
  endtask

  task automatic t_good_record();
    int lat;
    put_record(48'h0A1B2C3D4E5F, 8'h77, 1);
    run_load(lat);
    check("R7 latency", lat, 17);
    check("R4 mac", mac_addr, 48'h0A1B2C3D4E5F);
    check("R5 valid", valid, 1);
    check("R2 read count", rd_cnt, 8);
    for (int j = 0; j < 8; j++) check("R2 read addr", rd_log[j], j*16);
    @(negedge clk);
    check("R7 done width", done, 0);
  endtask

  task automatic t_mirror();
    int lat;
    put_record(48'h800000000001, 8'h00, 1);
    rom_mem[0] = 8'h01;
    run_load(lat);
    check("R3 first octet from 0x01", mac_addr[47:40], 8'h80);
    check("R3 last octet", mac_addr[7:0], 8'h01);
    check("R5 valid mirror", valid, 1);
  endtask

  task automatic t_zero_mac();
    int lat;
    put_record(48'h0, 8'h00, 1);
    run_load(lat);
    check("R4 zero mac", mac_addr, 0);
    check("R5 zero mac valid", valid, 1);
  endtask

  task automatic t_bad_sum();
    int lat;
    put_record(48'hDEADBEEF0102, 8'h55, 0);
    run_load(lat);
    check("R6 valid low", valid, 0);
    check("R6 mac still loaded", mac_addr, 48'hDEADBEEF0102);
  endtask

  task automatic t_tail_ignored();
    int lat;
    put_record(48'h123456789ABC, 8'h00, 1);
    run_load(lat);
    check("R4 mac A", mac_addr, 48'h123456789ABC);
    put_record(48'h123456789ABC, 8'hC3, 1);
    run_load(lat);
    check("R4 mac with other tail", mac_addr, 48'h123456789ABC);
    check("R5 valid other tail", valid, 1);
  endtask

  task automatic t_hold();
    logic [47:0] m;
    logic v;
    m = mac_addr;
    v = valid;
    for (int a = 0; a < 128; a += 16) rom_mem[a] = 8'h3C;
    repeat (20) @(negedge clk);
    check("R8 mac hold", mac_addr, m);
    check("R8 valid hold", valid, v);
  endtask

  task automatic t_start_busy();
    int k;
    int dones;
    put_record(48'hA0B0C0D0E0F0, 8'h11, 1);
    rd_cnt = 0;
    dones = 0;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (k = 0; k < 40; k++) begin
      @(negedge clk);
      if (done) dones++;
    end
    check("R9 single done", dones, 1);
    check("R9 reads", rd_cnt, 8);
    check("R9 mac", mac_addr, 48'hA0B0C0D0E0F0);
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #200000;
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_up();
  end

  initial begin
    for (int a = 0; a < 256; a++) rom_mem[a] = 8'hA5;
    start = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_idle_quiet();
    t_good_record();
    t_mirror();
    t_zero_mac();
    t_bad_sum();
    t_tail_ignored();
    t_hold();
    t_start_busy();
    finish_up();
  end
endmodule